// File: doc/BRIEF.md
# Paired-Start Converter Parallel Read Sequencer

This block sits on the host side of a six-channel converter that samples all of its channels at once. The converter has a 16-bit parallel result bus. A single trigger starts a capture cycle. The block latches a three-bit pair mask and pulses a separate active-low start line for each enabled channel pair. It then watches the converter's busy line, through a two-flop synchroniser, for the falling edge that marks the end of conversion.

When that edge arrives, the block lowers chip-select for the whole burst. It pulses the read strobe once per enabled channel and captures the bus on the last cycle of each read-low window. The captured words go into a flat six-word frame, which is announced by a one-cycle valid pulse.

If busy never falls within a parameterised number of cycles, the block gives up, raises a sticky error flag and skips the read. A trigger that arrives while a capture is under way is dropped and raises a sticky overrun flag. The converter is held in parallel, word-wide mode by two constant select outputs.

Top module: `adc_pair_reader`

## Requirements
- R1: After reset, all start lines, cs_n and rd_n are high, frame_valid, overrun and timeout_err are low, and ser_par_sel and word_byte_sel are always driven low.
- R2: A trigger accepted in idle with a nonzero pair_en drives low together, for exactly START_LOW cycles, the start lines of the enabled pairs. Bit 0 is channels 1–2, bit 1 is channels 3–4 and bit 2 is channels 5–6. Lines of disabled pairs stay high. A trigger with pair_en equal to zero starts nothing.
- R3: No read activity (cs_n low) happens while the converter reports busy, or while any start line is low. Reading begins only after the synchronised busy falling edge.
- R4: A read burst holds cs_n low throughout. It pulses rd_n low once per enabled channel, that is twice the number of enabled pairs. Each pulse is low for RD_LOW cycles, and consecutive pulses are separated by RD_HIGH high cycles. rd_n is never low while cs_n is high.
- R5: The bus is captured on the last cycle of each rd_n low window, in ascending channel order. Channel k (1..6) lands in frame[16*(k-1) +: 16]. Channels of disabled pairs read as zero. Bus values outside the read window never reach the frame.
- R6: frame_valid pulses high for one cycle after the last read. The frame stays unchanged until the next accepted trigger.
- R7: A trigger arriving while the block is not idle, including the frame_valid cycle, is ignored and sets overrun, which stays set until reset.
- R8: If busy does not fall within TIMEOUT cycles after the start lines return high, the block returns to idle. It sets a sticky timeout_err, issues no cs_n or rd_n activity and gives no frame_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Start a capture cycle |
| pair_en | input | 3 | Enabled channel pairs, bit i = channels 2i+1 and 2i+2 |
| busy | input | 1 | Converter busy, asynchronous |
| bus_data | input | 16 | Converter parallel result bus |
| start_n | output | 3 | Active-low conversion start, one per pair |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| ser_par_sel | output | 1 | Interface select, held low for parallel |
| word_byte_sel | output | 1 | Width select, held low for word mode |
| frame_valid | output | 1 | One-cycle pulse, frame complete |
| frame | output | 96 | Six 16-bit results, channel 1 in the low word |
| overrun | output | 1 | Sticky, trigger dropped while busy |
| timeout_err | output | 1 | Sticky, busy never fell in time |

## Verification
The completion of a frame and a new trigger can land in the same cycle: the frame_valid cycle still counts as busy. The bench provokes this by holding trigger high exactly in the cycle where it sees frame_valid. It then requires overrun to be set and no start line to fall in the following cycles. A trigger that arrives mid-conversion is also tested, and the frame that follows must still hold exactly one clean burst of reads.

// File: rtl/adc_pair_reader.sv
module adc_pair_reader #(
  parameter int DW        = 16,
  parameter int NPAIR     = 3,
  parameter int START_LOW = 4,
  parameter int RD_LOW    = 3,
  parameter int RD_HIGH   = 2,
  parameter int TIMEOUT   = 400
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trigger,
  input  logic [NPAIR-1:0]        pair_en,
  input  logic                    busy,
  input  logic [DW-1:0]           bus_data,
  output logic [NPAIR-1:0]        start_n,
  output logic                    cs_n,
  output logic                    rd_n,
  output logic                    ser_par_sel,
  output logic                    word_byte_sel,
  output logic                    frame_valid,
  output logic [2*NPAIR*DW-1:0]   frame,
  output logic                    overrun,
  output logic                    timeout_err
);
  localparam int NCH = 2 * NPAIR;
  localparam int CW  = $clog2(TIMEOUT + START_LOW + RD_LOW + RD_HIGH + 1);
  localparam int WW  = $clog2(NCH + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WAIT, S_RDLO, S_RDHI, S_DONE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [WW-1:0]    ch;
  logic [NPAIR-1:0] mask;
  logic             b1, b2, b3;
  logic             busy_fall;
  logic [WW-1:0]    ch_after;

  function automatic logic [WW-1:0] next_ch(input logic [WW-1:0] from, input logic [NPAIR-1:0] m);
    next_ch = WW'(NCH);
    for (int k = NCH - 1; k >= 0; k--)
      if (k >= int'(from) && m[k/2]) next_ch = WW'(k);
  endfunction

  assign busy_fall     = b3 & ~b2;
  assign ch_after      = next_ch(ch + WW'(1), mask);
  assign start_n       = (st == S_START) ? ~mask : '1;
  assign cs_n          = !(st == S_RDLO || st == S_RDHI);
  assign rd_n          = (st != S_RDLO);
  assign frame_valid   = (st == S_DONE);
  assign ser_par_sel   = 1'b0;
  assign word_byte_sel = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {b3, b2, b1} <= '0;
      st          <= S_IDLE;
      cnt         <= '0;
      ch          <= '0;
      mask        <= '0;
      frame       <= '0;
      overrun     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      {b3, b2, b1} <= {b2, b1, busy};
      if (trigger && st != S_IDLE) overrun <= 1'b1;
      case (st)
        S_IDLE: if (trigger && |pair_en) begin
          mask  <= pair_en;
          frame <= '0;
          cnt   <= '0;
          st    <= S_START;
        end
        S_START: if (cnt == CW'(START_LOW - 1)) begin
          cnt <= '0;
          st  <= S_WAIT;
        end else cnt <= cnt + 1'b1;
        S_WAIT: if (busy_fall) begin
          cnt <= '0;
          ch  <= next_ch('0, mask);
          st  <= S_RDLO;
        end else if (cnt == CW'(TIMEOUT - 1)) begin
          timeout_err <= 1'b1;
          st          <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_RDLO: if (cnt == CW'(RD_LOW - 1)) begin
          frame[int'(ch)*DW +: DW] <= bus_data;
          cnt <= '0;
          ch  <= ch_after;
          st  <= (ch_after == WW'(NCH)) ? S_DONE : S_RDHI;
        end else cnt <= cnt + 1'b1;
        S_RDHI: if (cnt == CW'(RD_HIGH - 1)) begin
          cnt <= '0;
          st  <= S_RDLO;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_pair_reader_sva.sv
module adc_pair_reader_sva #(
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPAIR-1:0] start_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             frame_valid,
  input logic             overrun,
  input logic             timeout_err
);
  assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&start_n) |=> $stable(start_n));

  assert_no_read_during_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (&start_n));

  assert_rd_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  assert_rd_min_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind adc_pair_reader adc_pair_reader_sva #(.NPAIR(NPAIR)) u_sva (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
  .frame_valid(frame_valid), .overrun(overrun), .timeout_err(timeout_err)
);

// File: tb/tb_adc_pair_reader.sv
module tb_adc_pair_reader;
  localparam int CLK_PERIOD = 10;
  localparam int SL = 3, RL = 3, RH = 2, TO = 60, CONV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigger = 1'b0;
  logic [2:0]  pair_en = '0;
  logic        busy = 1'b0;
  logic [15:0] bus_data;
  logic [2:0]  start_n;
  logic        cs_n, rd_n, ser_par_sel, word_byte_sel, frame_valid, overrun, timeout_err;
  logic [95:0] frame;

  adc_pair_reader #(.START_LOW(SL), .RD_LOW(RL), .RD_HIGH(RH), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .pair_en(pair_en), .busy(busy),
    .bus_data(bus_data), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
    .ser_par_sel(ser_par_sel), .word_byte_sel(word_byte_sel), .frame_valid(frame_valid),
    .frame(frame), .overrun(overrun), .timeout_err(timeout_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [15:0] base = 16'h0;
  logic        hang = 1'b0;

  logic [2:0] start_q = 3'b111, conv_mask = '0;
  logic       rd_q = 1'b1, cs_q = 1'b1;
  int bcnt = 0, ptr = 6;
  int rd_falls = 0, cs_falls = 0, valid_cnt = 0, viol = 0, rd_badw = 0, gap_bad = 0;
  int start_falls [3];
  int start_w [3];
  int start_lo [3];
  int rd_lo = 0, rd_hi = 0;

  function automatic int nxt(int from, logic [2:0] m);
    for (int k = from; k < 6; k++) if (m[k/2]) return k;
    return 6;
  endfunction

  assign bus_data = (!cs_n && !rd_n) ? ((ptr < 6) ? base + 16'(ptr) : 16'hBAD0) : 16'hDEAD;

  always @(posedge clk) begin
    start_q <= start_n;
    rd_q    <= rd_n;
    cs_q    <= cs_n;
    if (|(start_n & ~start_q)) begin
      conv_mask <= start_n & ~start_q;
      ptr  <= nxt(0, start_n & ~start_q);
      busy <= 1'b1;
      bcnt <= CONV;
    end else begin
      if (busy && !hang) begin
        if (bcnt == 0) busy <= 1'b0; else bcnt <= bcnt - 1;
      end
      if (!rd_q && rd_n) ptr <= nxt(ptr + 1, conv_mask);
    end
    for (int i = 0; i < 3; i++) begin
      if (start_q[i] && !start_n[i]) start_falls[i] <= start_falls[i] + 1;
      if (!start_n[i]) start_lo[i] <= start_lo[i] + 1;
      if (!start_q[i] && start_n[i]) begin start_w[i] <= start_lo[i]; start_lo[i] <= 0; end
    end
    if (rd_q && !rd_n) begin
      rd_falls <= rd_falls + 1;
      if (rd_hi != 0 && rd_hi != RH) gap_bad <= gap_bad + 1;
      rd_hi <= 0;
    end else if (!cs_n && rd_n) rd_hi <= rd_hi + 1;
    else if (cs_n) rd_hi <= 0;
    if (!rd_n) rd_lo <= rd_lo + 1;
    if (!rd_q && rd_n) begin
      if (rd_lo != RL) rd_badw <= rd_badw + 1;
      rd_lo <= 0;
    end
    if (cs_q && !cs_n) cs_falls <= cs_falls + 1;
    if (frame_valid) valid_cnt <= valid_cnt + 1;
    if ((!cs_n && busy) || (!rd_n && cs_n) || (!cs_n && !(&start_n))) viol <= viol + 1;
  end

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    @(negedge clk);
    rd_falls = 0; cs_falls = 0; valid_cnt = 0; viol = 0; rd_badw = 0; gap_bad = 0;
    for (int i = 0; i < 3; i++) begin start_falls[i] = 0; start_w[i] = 0; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; trigger = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_trig(logic [2:0] m);
    pair_en = m; trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 400; i++) begin
      if (frame_valid) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [95:0] exp_frame(logic [2:0] m, logic [15:0] b);
    logic [95:0] f = '0;
    for (int c = 0; c < 6; c++) if (m[c/2]) f[c*16 +: 16] = b + 16'(c);
    return f;
  endfunction

  localparam logic [18:0] VEC [6] = '{
    {3'b111, 16'h1000}, {3'b001, 16'h2100}, {3'b010, 16'h3200},
    {3'b100, 16'h4300}, {3'b101, 16'h5400}, {3'b110, 16'h6500}};

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin start_falls[i] = 0; start_w[i] = 0; start_lo[i] = 0; end
    do_reset();
    chk("R1 reset outputs", {start_n, cs_n, rd_n, frame_valid, overrun, timeout_err},
        {3'b111, 1'b1, 1'b1, 3'b000});
    chk("R1 mode selects", {ser_par_sel, word_byte_sel}, 2'b00);

    for (int v = 0; v < 6; v++) begin
      logic [2:0] m = VEC[v][18:16];
      base = VEC[v][15:0];
      clr_counts();
      pulse_trig(m);
      wait_valid();
      chk("R5 frame contents", frame, exp_frame(m, base));
      chk("R6 valid seen", 96'(frame_valid), 96'(1));
      @(negedge clk);
      chk("R6 valid one cycle", 96'(frame_valid), 96'(0));
      chk("R4 read count", 96'(rd_falls), 96'(2 * $countones(m)));
      chk("R4 one cs burst", 96'(cs_falls), 96'(1));
      chk("R4 rd widths and gaps", 96'(rd_badw + gap_bad), 96'(0));
      chk("R3 no read overlap with busy or start", 96'(viol), 96'(0));
      for (int i = 0; i < 3; i++) begin
        chk("R2 start pulses", 96'(start_falls[i]), 96'(m[i] ? 1 : 0));
        if (m[i]) chk("R2 start width", 96'(start_w[i]), 96'(SL));
      end
      repeat (5) @(negedge clk);
      chk("R6 frame held", frame, exp_frame(m, base));
    end

    clr_counts();
    pulse_trig(3'b000);
    repeat (40) @(negedge clk);
    chk("R2 zero mask ignored", 96'(start_falls[0] + start_falls[1] + start_falls[2] + valid_cnt), 96'(0));

    do_reset();
    clr_counts();
    base = 16'h7000;
    pulse_trig(3'b111);
    repeat (5) @(negedge clk);
    pulse_trig(3'b001);
    chk("R7 overrun mid conversion", 96'(overrun), 96'(1));
    wait_valid();
    chk("R7 frame unaffected", frame, exp_frame(3'b111, base));
    chk("R7 single burst", 96'(rd_falls), 96'(6));

    do_reset();
    clr_counts();
    base = 16'h7700;
    pulse_trig(3'b010);
    wait_valid();
    trigger = 1'b1; pair_en = 3'b111;
    @(negedge clk);
    trigger = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 trigger on valid cycle sets overrun", 96'(overrun), 96'(1));
    chk("R7 trigger on valid cycle ignored", 96'(start_falls[1]), 96'(1));
    chk("R7 no extra start", 96'(start_falls[0] + start_falls[2]), 96'(0));

    do_reset();
    clr_counts();
    hang = 1'b1;
    pulse_trig(3'b001);
    repeat (TO + SL + 10) @(negedge clk);
    chk("R8 timeout flag", 96'(timeout_err), 96'(1));
    chk("R8 no read and no valid", 96'(cs_falls + rd_falls + valid_cnt), 96'(0));
    hang = 1'b0;
    repeat (CONV + 10) @(negedge clk);
    clr_counts();
    base = 16'h8800;
    pulse_trig(3'b100);
    wait_valid();
    chk("R8 recovers after timeout", frame, exp_frame(3'b100, base));
    chk("R8 flag sticky", 96'(timeout_err), 96'(1));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule